// File: doc/BRIEF.md
# Network Clock Synchronizer Mode Controller

This block is the control state machine of a network timing synchronizer. It decides whether the synchronizer runs from its local oscillator (Free-run), tracks a network reference (Normal), or holds its last good frequency (Holdover). Holdover comes in two forms: one the machine enters on its own when the reference fails, and one that software requests. It also owns the reset sequence. A reset pulse on the pin must be wide enough to count, and an initialization delay must expire before the machine leaves Reset. While in Reset, the block drives the enables that halt the arithmetic, stop the output clocks and shut the processor port.

The phase-locked loops, reference frequency detection and clock synthesis sit outside this block. They are seen here only as flags: `ref_good` for reference quality, `ref_sel_chg` for a change of selected reference, and `acq_done` for completed acquisition. All inputs are synchronous to `clk`. `us_tick` is a one-cycle pulse once per microsecond and paces both reset timers. There is no streaming data path, so every pin is a plain control or status level.

Top module: `clksync_mode_ctrl`

## Requirements
- R1: While `arst_n` is low and on its release, `state_code` is 3'b011 (Reset) and `lock` is 0. The state encoding is Normal=3'b000, Holdover=3'b001, Free-run=3'b010, Reset=3'b011 and Automatic Holdover=3'b101. The low two bits carry the mode code: 00 Normal, 01 Holdover, 10 Free-run.
- R2: A low level on `rst_pin_n` sends the machine to Reset only once `us_tick` has been seen RST_MIN_US (default 1) times while the pin stays low. A shorter low pulse leaves the state unchanged. Once the reset is qualified, Reset has priority over every other input, `mode_sel` included.
- R3: In Reset with the pin high, the machine moves to Free-run after INIT_US (default 500) ticks. Any earlier cycle stays in Reset.
- R4: `arith_halt`, `clk_stop` and `cpu_port_off` are 1 exactly while the state is Reset.
- R5: Outside Reset, `mode_sel`=2'b10 moves the machine to Free-run on the next clock from any state.
- R6: From Free-run or Holdover, `mode_sel`=2'b00 with `ref_good`=1 moves the machine to Normal.
- R7: In Normal with `mode_sel`=2'b00, `ref_good`=0 moves the machine to Automatic Holdover.
- R8: Outside Reset, `mode_sel`=2'b01 or a pulse on `ref_sel_chg` (with `mode_sel` not 2'b10) moves the machine to Holdover.
- R9: In Automatic Holdover with `mode_sel`=2'b00 and `auto_rec_dis`=0, `ref_good`=1 returns the machine to Normal.
- R10: With `auto_rec_dis`=1, Automatic Holdover returns to Normal only on a falling edge of `man_release` that follows a rising edge. Both edges must fall inside the current stay in Automatic Holdover, with `ref_good` at 1 throughout. The recorded rising edge is forgotten when `ref_good` drops or the state leaves Automatic Holdover.
- R11: `lock` is 1 only in Normal, and only from the cycle after `acq_done` has been seen high while in Normal. It is 0 on the cycle Normal is entered and 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-up reset, active low |
| rst_pin_n | input | 1 | Reset request pin, active low, width-qualified |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| mode_sel | input | 2 | Mode request: 00 Normal, 01 Holdover, 10 Free-run |
| ref_good | input | 1 | Selected reference is of good quality |
| ref_sel_chg | input | 1 | One-cycle pulse on a change of selected reference |
| auto_rec_dis | input | 1 | Disables automatic recovery from Automatic Holdover |
| man_release | input | 1 | Manual holdover release, acted on as a full high pulse |
| acq_done | input | 1 | Reference acquisition complete |
| state_code | output | 3 | Current state code |
| lock | output | 1 | Locked status |
| arith_halt | output | 1 | Halts loop arithmetic |
| clk_stop | output | 1 | Stops generated clocks |
| cpu_port_off | output | 1 | Disables the processor port |

## Verification
The state machine is driven through each of its arcs in turn. The walk covers the normal lock and unlock loop, automatic recovery with the disable bit clear, and manual release with the disable bit set. The manual release is given as a correct rise-and-fall pulse, as a pulse while the reference is failed, and as a rising edge recorded before the state is left. These patterns tell a true edge tracker apart from one that reacts to levels or keeps a stale record. The reset pin is tried with a glitch that falls between ticks and with a long low, which tells the width filter apart from a plain level reset. The initialization exit is probed on both sides of its boundary. A behavioural model is compared against every output on every clock.

// File: rtl/clksync_pkg.sv
package clksync_pkg;
  typedef enum logic [2:0] {
    ST_NORM = 3'b000,
    ST_HOLD = 3'b001,
    ST_FREE = 3'b010,
    ST_RST  = 3'b011,
    ST_AUTO = 3'b101
  } sync_st_e;

  localparam logic [1:0] MS_NORMAL = 2'b00;
  localparam logic [1:0] MS_HOLD   = 2'b01;
  localparam logic [1:0] MS_FREE   = 2'b10;
endpackage

// File: rtl/clksync_rst_qual.sv
module clksync_rst_qual #(
  parameter int RST_MIN_US = 1,
  parameter int INIT_US    = 500
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_pin_n,
  input  logic us_tick,
  input  logic in_reset,
  output logic rst_req,
  output logic init_done
);
  localparam int LW = $clog2(RST_MIN_US + 1) + 1;
  localparam int IW = $clog2(INIT_US + 1) + 1;
  localparam logic [LW-1:0] LOW_MAX  = LW'(RST_MIN_US);
  localparam logic [IW-1:0] INIT_MAX = IW'(INIT_US);

  logic [LW-1:0] low_cnt_q;
  logic [IW-1:0] init_cnt_q;

  // pin low time, counted in ticks, saturating at the qualifying width
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      low_cnt_q <= '0;
    else if (rst_pin_n)
      low_cnt_q <= '0;
    else if (us_tick && low_cnt_q < LOW_MAX)
      low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign rst_req = (low_cnt_q == LOW_MAX);

  // initialization timer runs only in Reset once the request is gone
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      init_cnt_q <= '0;
    else if (!in_reset || rst_req)
      init_cnt_q <= '0;
    else if (us_tick && init_cnt_q < INIT_MAX)
      init_cnt_q <= init_cnt_q + 1'b1;
  end

  assign init_done = (init_cnt_q == INIT_MAX);

  // R2
  pin_high_clears_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_pin_n |=> !rst_req);
endmodule

// File: rtl/clksync_rel_track.sv
module clksync_rel_track (
  input  logic clk,
  input  logic arst_n,
  input  logic active,
  input  logic ref_good,
  input  logic man_release,
  output logic rel_done
);
  logic rel_d_q;
  logic armed_q;
  logic rise, fall;

  assign rise = man_release & ~rel_d_q;
  assign fall = ~man_release & rel_d_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rel_d_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      rel_d_q <= man_release;
      if (!active || !ref_good) armed_q <= 1'b0;
      else if (rise)            armed_q <= 1'b1;
      else if (fall)            armed_q <= 1'b0;
    end
  end

  assign rel_done = active & ref_good & armed_q & fall;

  // R10
  record_cleared_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!active || !ref_good) |=> !armed_q);
endmodule

// File: rtl/clksync_mode_fsm.sv
module clksync_mode_fsm
  import clksync_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       rst_req,
  input  logic       init_done,
  input  logic       rel_done,
  input  logic [1:0] mode_sel,
  input  logic       ref_good,
  input  logic       ref_sel_chg,
  input  logic       auto_rec_dis,
  input  logic       acq_done,
  output sync_st_e   state_q,
  output logic       lock
);
  sync_st_e state_d;
  logic     acq_seen_q;

  always_comb begin
    state_d = state_q;
    if (rst_req) begin
      state_d = ST_RST;
    end else if (state_q == ST_RST) begin
      if (init_done) state_d = ST_FREE;
    end else if (mode_sel == MS_FREE) begin
      state_d = ST_FREE;
    end else if (mode_sel == MS_HOLD || ref_sel_chg) begin
      state_d = ST_HOLD;
    end else if (mode_sel == MS_NORMAL) begin
      unique case (state_q)
        ST_FREE, ST_HOLD: if (ref_good) state_d = ST_NORM;
        ST_NORM:          if (!ref_good) state_d = ST_AUTO;
        ST_AUTO:          if (ref_good && (!auto_rec_dis || rel_done)) state_d = ST_NORM;
        default:          state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q    <= ST_RST;
      acq_seen_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      acq_seen_q <= (state_q == ST_NORM) && (state_d == ST_NORM) && (acq_seen_q || acq_done);
    end
  end

  assign lock = (state_q == ST_NORM) && acq_seen_q;

  // R5
  force_free_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q != ST_RST && !rst_req && mode_sel == MS_FREE) |=> state_q == ST_FREE);

  // R7
  auto_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_NORM && !rst_req && mode_sel == MS_NORMAL && !ref_sel_chg && !ref_good)
      |=> state_q == ST_AUTO);

  // R11
  lock_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_NORM && $past(state_q) != ST_NORM) |-> !lock);

  // R3
  init_exit_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ($past(state_q) == ST_RST && state_q != ST_RST) |-> $past(init_done));

  // R10
  manual_exit_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ($past(state_q) == ST_AUTO && state_q == ST_NORM && $past(auto_rec_dis)) |-> $past(rel_done));
endmodule

// File: rtl/clksync_mode_ctrl.sv
module clksync_mode_ctrl
  import clksync_pkg::*;
#(
  parameter int RST_MIN_US = 1,
  parameter int INIT_US    = 500
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       rst_pin_n,
  input  logic       us_tick,
  input  logic [1:0] mode_sel,
  input  logic       ref_good,
  input  logic       ref_sel_chg,
  input  logic       auto_rec_dis,
  input  logic       man_release,
  input  logic       acq_done,
  output logic [2:0] state_code,
  output logic       lock,
  output logic       arith_halt,
  output logic       clk_stop,
  output logic       cpu_port_off
);
  sync_st_e st;
  logic     rst_req, init_done, rel_done;
  logic     in_reset;

  assign in_reset = (st == ST_RST);

  clksync_rst_qual #(.RST_MIN_US(RST_MIN_US), .INIT_US(INIT_US)) u_qual (
    .clk(clk), .arst_n(arst_n), .rst_pin_n(rst_pin_n), .us_tick(us_tick),
    .in_reset(in_reset), .rst_req(rst_req), .init_done(init_done)
  );

  clksync_rel_track u_rel (
    .clk(clk), .arst_n(arst_n), .active(st == ST_AUTO), .ref_good(ref_good),
    .man_release(man_release), .rel_done(rel_done)
  );

  clksync_mode_fsm u_fsm (
    .clk(clk), .arst_n(arst_n), .rst_req(rst_req), .init_done(init_done),
    .rel_done(rel_done), .mode_sel(mode_sel), .ref_good(ref_good),
    .ref_sel_chg(ref_sel_chg), .auto_rec_dis(auto_rec_dis), .acq_done(acq_done),
    .state_q(st), .lock(lock)
  );

  assign state_code   = st;
  assign arith_halt   = in_reset;
  assign clk_stop     = in_reset;
  assign cpu_port_off = in_reset;

  // R4
  halt_on_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_req |=> (arith_halt && clk_stop && cpu_port_off));
endmodule

// File: tb/tb_clksync_mode_ctrl.sv
module tb_clksync_mode_ctrl;
  localparam int RMIN = 1;
  localparam int INIT = 500;
  localparam int C_NORM = 0, C_HOLD = 1, C_FREE = 2, C_RST = 3, C_AUTO = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic arst_n = 1'b0, rst_pin_n = 1'b1;
  logic [1:0] mode_sel = 2'b10;
  logic ref_good = 0, ref_sel_chg = 0, auto_rec_dis = 0, man_release = 0, acq_done = 0;
  logic [2:0] state_code;
  logic lock, arith_halt, clk_stop, cpu_port_off;
  int tcnt = 0;
  logic us_tick;
  assign us_tick = (tcnt % 4 == 3);

  clksync_mode_ctrl #(.RST_MIN_US(RMIN), .INIT_US(INIT)) dut (.*);

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int  m_st = C_RST, m_low = 0, m_init = 0;
  bit  m_prev = 0, m_armed = 0, m_acq = 0;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_st = C_RST; m_low = 0; m_init = 0; m_prev = 0; m_armed = 0; m_acq = 0;
    end else begin
      bit req, idone, rel, rise, fall;
      int nx;
      req   = (m_low >= RMIN);
      idone = (m_init >= INIT);
      rise  = man_release && !m_prev;
      fall  = !man_release && m_prev;
      rel   = (m_st == C_AUTO) && ref_good && m_armed && fall;
      nx = m_st;
      if (req) nx = C_RST;
      else if (m_st == C_RST) begin if (idone) nx = C_FREE; end
      else if (mode_sel == 2) nx = C_FREE;
      else if (mode_sel == 1 || ref_sel_chg) nx = C_HOLD;
      else if (mode_sel == 0) begin
        if ((m_st == C_FREE || m_st == C_HOLD) && ref_good) nx = C_NORM;
        else if (m_st == C_NORM && !ref_good) nx = C_AUTO;
        else if (m_st == C_AUTO && ref_good && (!auto_rec_dis || rel)) nx = C_NORM;
      end
      m_acq   = (m_st == C_NORM && nx == C_NORM) && (m_acq || acq_done);
      m_armed = (m_st != C_AUTO || !ref_good) ? 0 : rise ? 1 : fall ? 0 : m_armed;
      m_low   = rst_pin_n ? 0 : (us_tick && m_low < RMIN) ? m_low + 1 : m_low;
      m_init  = (m_st != C_RST || req) ? 0 : (us_tick && m_init < INIT) ? m_init + 1 : m_init;
      m_prev  = man_release;
      m_st    = nx;
    end
  end

  always @(posedge clk) begin
    tcnt <= tcnt + 1;
    cycles <= cycles + 1;
  end

  always @(negedge clk) if (!finished) begin
    chk(state_code == m_st[2:0], "R1 model state", state_code, m_st);
    chk(lock == (m_st == C_NORM && m_acq), "R11 model lock", lock, (m_st == C_NORM && m_acq));
    chk(arith_halt == (m_st == C_RST) && clk_stop == (m_st == C_RST) && cpu_port_off == (m_st == C_RST),
        "R4 model enables", arith_halt, (m_st == C_RST));
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_up;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 150000 && !finished) begin
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    finish_up();
  end

  initial begin
    cyc(3);
    chk(state_code == 3'b011 && lock == 0, "R1 reset state", state_code, 3);
    chk(arith_halt && clk_stop && cpu_port_off, "R4 enables in reset", arith_halt, 1);
    arst_n = 1'b1;
    cyc(1990);
    chk(state_code == 3'b011, "R3 still initializing", state_code, 3);
    cyc(20);
    chk(state_code == 3'b010, "R3 free-run after init", state_code, 2);
    chk(!arith_halt && !clk_stop && !cpu_port_off, "R4 enables off", arith_halt, 0);
    // Free-run -> Normal, lock qualification
    acq_done = 1; ref_good = 1; mode_sel = 2'b00;
    cyc(1);
    chk(state_code == 3'b000, "R6 free to normal", state_code, 0);
    chk(lock == 0, "R11 no lock on entry", lock, 0);
    cyc(1);
    chk(lock == 1, "R11 lock after acq", lock, 1);
    // Normal -> Auto holdover -> automatic recovery
    ref_good = 0;
    cyc(1);
    chk(state_code == 3'b101, "R7 auto holdover", state_code, 5);
    chk(lock == 0, "R11 lock off in holdover", lock, 0);
    cyc(3);
    ref_good = 1;
    cyc(1);
    chk(state_code == 3'b000, "R9 auto recovery", state_code, 0);
    // manual release path
    auto_rec_dis = 1; ref_good = 0;
    cyc(1);
    ref_good = 1;
    cyc(3);
    chk(state_code == 3'b101, "R10 waits for release", state_code, 5);
    man_release = 1; cyc(2);
    chk(state_code == 3'b101, "R10 rise alone not enough", state_code, 5);
    man_release = 0; cyc(1);
    chk(state_code == 3'b000, "R10 rise then fall releases", state_code, 0);
    // pulse while reference failed is not recorded
    ref_good = 0; cyc(1);
    man_release = 1; cyc(2);
    ref_good = 1; cyc(1);
    man_release = 0; cyc(2);
    chk(state_code == 3'b101, "R10 pulse with bad ref ignored", state_code, 5);
    // rising edge recorded, then state left: record forgotten
    man_release = 1; cyc(1);
    mode_sel = 2'b10; cyc(1);
    chk(state_code == 3'b010, "R5 forced free from auto", state_code, 2);
    mode_sel = 2'b00; cyc(1);
    ref_good = 0; cyc(1);
    ref_good = 1; cyc(1);
    man_release = 0; cyc(2);
    chk(state_code == 3'b101, "R10 record cleared on exit", state_code, 5);
    // holdover requests
    auto_rec_dis = 0; cyc(1);
    chk(state_code == 3'b000, "R9 recovery with disable cleared", state_code, 0);
    ref_sel_chg = 1; cyc(1);
    ref_sel_chg = 0;
    chk(state_code == 3'b001, "R8 ref change to holdover", state_code, 1);
    cyc(1);
    chk(state_code == 3'b000, "R6 holdover to normal", state_code, 0);
    mode_sel = 2'b01; cyc(1);
    chk(state_code == 3'b001, "R8 mode 01 holdover", state_code, 1);
    mode_sel = 2'b10; cyc(1);
    chk(state_code == 3'b010, "R5 forced free from holdover", state_code, 2);
    // reset pin glitch between ticks
    while (tcnt % 4 != 0) cyc(1);
    rst_pin_n = 0; cyc(2);
    rst_pin_n = 1; cyc(2);
    chk(state_code == 3'b010, "R2 glitch ignored", state_code, 2);
    rst_pin_n = 0; cyc(12);
    chk(state_code == 3'b011, "R2 long low resets", state_code, 3);
    chk(arith_halt && cpu_port_off, "R4 enables after pin reset", arith_halt, 1);
    rst_pin_n = 1; cyc(1990);
    chk(state_code == 3'b011, "R2 mode 10 does not override reset", state_code, 3);
    cyc(30);
    chk(state_code == 3'b010, "R3 free-run after pin reset", state_code, 2);
    finish_up();
  end
endmodule